// File: doc/BRIEF.md
# Atomic Transfer Lock Sequencer

This block arbitrates a shared, wired-low lock line for a bus master that issues indivisible read-then-write sequences and interrupt-acknowledge transfers on a multiplexed address/data bus. Any agent on the bus may pull the line low, and a low line means some agent owns it. When the core asks for an atomic sequence, the block looks at a synchronized copy of the line. If another agent holds it, the block withholds the grant. When the line is free, the block grants the core and pulls the line low from the read address phase up to the write address phase. Interrupt-acknowledge transfers are locked from grant until the core reports completion.

The line also serves as a strap. Its level at the end of reset selects a float mode in which the block neither pulls the line nor grants anything until the next reset. The pad is open-drain, so the block only reports whether to sink the line and never drives it high.

Top module: `rmw_lock_ctrl`

## Requirements
- R1: After reset is released with the line high, `lock_granted`, `lock_pull` and `float_mode` are all 0.
- R2: With the synchronized line high (free) and the block idle, raising `atomic_req` sets `lock_granted` at the next clock edge, and `lock_pull` stays 0 until the read address phase.
- R3: While the line is low, an atomic or interrupt-acknowledge request is not granted. The line passes through a two-flop synchronizer, so after the line rises the grant appears on the third rising edge and not earlier.
- R4: When granted and waiting, a cycle with `addr_state`=1 and `is_write`=0 (read address phase) makes `lock_pull` 1 from the next edge. It stays 1, with the grant, through any number of following data cycles.
- R5: While the read-modify-write lock is held, a cycle with `addr_state`=1 and `is_write`=1 (write address phase) clears both `lock_pull` and `lock_granted` at the next edge.
- R6: An interrupt-acknowledge request (`intack_req`) on a free line sets both `lock_granted` and `lock_pull` at the next edge. Both stay set until `done` is seen, and both clear at the edge that samples `done`=1.
- R7: Ordinary transfers never involve the lock. Toggling `addr_state` and `is_write` with no request pending leaves `lock_pull` and `lock_granted` at 0, whether the line is held by another agent or free.
- R8: If `atomic_req` and `intack_req` are raised together on a free line, the atomic sequence is chosen: the grant is set and `lock_pull` stays 0.
- R9: If the line is low at the first clock edge after reset release, `float_mode` becomes 1. While it is 1, requests are ignored (`lock_pull` and `lock_granted` stay 0). It persists until the next reset, and a reset with the line high clears it.
- R10: Asserting reset while a request is waiting for the line abandons the request. After release, no grant appears even once the line becomes free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Level of the shared lock line (0 = held) |
| atomic_req | input | 1 | Core requests an atomic read-modify-write sequence |
| intack_req | input | 1 | Core requests a locked interrupt-acknowledge transfer |
| addr_state | input | 1 | Bus is in an address phase this cycle |
| is_write | input | 1 | Current transfer is a write |
| done | input | 1 | Core signals the interrupt-acknowledge transfer has finished |
| lock_granted | output | 1 | Core may proceed with its locked sequence |
| lock_pull | output | 1 | 1 = sink the open-drain lock line low |
| float_mode | output | 1 | Strap selected float mode; outputs are to be three-stated |

## Verification
The bench models the wired-low line as the AND of this block's release and a second agent. It sweeps how long the other agent holds the line, and checks that the grant appears exactly three edges after release. A design with a missing or extra synchronizer stage would grant one edge early or late, and one that skipped the sample would grant while the line is still low. Read-to-write spacing and interrupt-acknowledge lengths are swept to catch a lock that drops during data cycles or outlives the write address phase. The bench also covers the reset strap, a reset in the middle of a wait, and simultaneous requests, which catch a float flag that follows the line after reset, a stale wait that resumes, and a reversed priority that pulls the line at grant.

// File: rtl/rmw_lock_pkg.sv
package rmw_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_RMW = 3'd1,
    ST_WAIT_ACK = 3'd2,
    ST_ARMED    = 3'd3,
    ST_HOLD_RMW = 3'd4,
    ST_HOLD_ACK = 3'd5
  } lk_state_e;

endpackage

// File: rtl/rmw_lock_sync.sv
// Multi-stage synchronizer for the asynchronous lock line level.
// Left without reset so it tracks the pad during reset for the strap.
module rmw_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stg_q;
      always_ff @(posedge clk) begin
        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk) begin
        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rmw_lock_strap.sv
// Captures the float strap once, on the first edge after reset release.
module rmw_lock_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  output logic float_mode
);

  logic armed_q, armed_d;
  logic float_q, float_d;
  logic cap_en;

  always_comb begin
    cap_en  = ~armed_q;
    armed_d = 1'b1;
    float_d = cap_en ? ~line_sync : float_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      float_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      float_q <= float_d;
    end
  end

  assign float_mode = float_q;

  // R9
  float_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(float_q));

endmodule

// File: rtl/rmw_lock_fsm.sv
// Request/grant sequencing and lock pull control.
module rmw_lock_fsm
  import rmw_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_free,
  input  logic float_mode,
  input  logic atomic_req,
  input  logic intack_req,
  input  logic addr_state,
  input  logic is_write,
  input  logic done,
  output logic lock_granted,
  output logic lock_pull
);

  lk_state_e state_q, state_d;
  logic rd_addr, wr_addr;

  assign rd_addr = addr_state & ~is_write;
  assign wr_addr = addr_state &  is_write;

  always_comb begin
    state_d = state_q;
    if (float_mode) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (atomic_req)      state_d = line_free ? ST_ARMED    : ST_WAIT_RMW;
          else if (intack_req) state_d = line_free ? ST_HOLD_ACK : ST_WAIT_ACK;
        end
        ST_WAIT_RMW: if (line_free) state_d = ST_ARMED;
        ST_WAIT_ACK: if (line_free) state_d = ST_HOLD_ACK;
        ST_ARMED:    if (rd_addr)   state_d = ST_HOLD_RMW;
        ST_HOLD_RMW: if (wr_addr)   state_d = ST_IDLE;
        ST_HOLD_ACK: if (done)      state_d = ST_IDLE;
        default:                    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign lock_granted = (state_q == ST_ARMED) | (state_q == ST_HOLD_RMW) |
                        (state_q == ST_HOLD_ACK);
  assign lock_pull    = (state_q == ST_HOLD_RMW) | (state_q == ST_HOLD_ACK);

  // R3
  held_line_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_granted && !line_free) |=> !lock_granted);

  // R4
  rd_addr_takes_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && rd_addr && !float_mode) |=> lock_pull);

  // R5
  wr_addr_frees_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD_RMW && wr_addr) |=> (!lock_pull && !lock_granted));

  // R6
  ack_holds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD_ACK && !done && !float_mode) |=> lock_pull);

  // R9
  float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    float_mode |=> (!lock_pull && !lock_granted));

endmodule

// File: rtl/rmw_lock_ctrl.sv
module rmw_lock_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic atomic_req,
  input  logic intack_req,
  input  logic addr_state,
  input  logic is_write,
  input  logic done,
  output logic lock_granted,
  output logic lock_pull,
  output logic float_mode
);

  logic line_sync;

  rmw_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (lock_in),
    .q   (line_sync)
  );

  rmw_lock_strap u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_sync  (line_sync),
    .float_mode (float_mode)
  );

  rmw_lock_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_free    (line_sync),
    .float_mode   (float_mode),
    .atomic_req   (atomic_req),
    .intack_req   (intack_req),
    .addr_state   (addr_state),
    .is_write     (is_write),
    .done         (done),
    .lock_granted (lock_granted),
    .lock_pull    (lock_pull)
  );

  // R6
  pull_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pull |-> lock_granted);

endmodule

// File: tb/rmw_lock_ctrl_tb.sv
module rmw_lock_ctrl_tb;

  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n, atomic_req, intack_req, addr_state, is_write, done;
  logic other_hold;
  logic lock_in;
  logic lock_granted, lock_pull, float_mode;
  int   n_chk  = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  // wired-low line: low if this block or the other agent sinks it
  assign lock_in = ~(lock_pull | other_hold);

  rmw_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .atomic_req(atomic_req),
    .intack_req(intack_req), .addr_state(addr_state), .is_write(is_write),
    .done(done), .lock_granted(lock_granted), .lock_pull(lock_pull),
    .float_mode(float_mode)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic hold_line);
    rst_n = 1'b0; other_hold = hold_line;
    atomic_req = 0; intack_req = 0; addr_state = 0; is_write = 0; done = 0;
    repeat (5) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  // finish a granted read-modify-write with n data cycles between phases
  task automatic finish_rmw(input int ndata, input string req);
    addr_state = 1; is_write = 0;
    step();
    chk("R4", lock_pull, 1'b1, {req, " pull after read address"});
    addr_state = 0;
    for (int i = 0; i < ndata; i++) begin
      step();
      chk("R4", lock_pull & lock_granted, 1'b1, "lock through data cycle");
    end
    addr_state = 1; is_write = 1;
    step();
    chk("R5", lock_pull, 1'b0, "pull after write address");
    chk("R5", lock_granted, 1'b0, "grant after write address");
    addr_state = 0; is_write = 0;
    settle();
  endtask

  initial begin
    do_reset(1'b0);
    // R1
    chk("R1", lock_granted, 1'b0, "grant after reset");
    chk("R1", lock_pull, 1'b0, "pull after reset");
    chk("R1", float_mode, 1'b0, "float after reset");
    settle();

    // R2 free line, sweep data cycle count
    for (int nd = 1; nd <= 4; nd++) begin
      atomic_req = 1;
      step();
      chk("R2", lock_granted, 1'b1, "grant on free line");
      chk("R2", lock_pull, 1'b0, "no pull before read address");
      atomic_req = 0;
      step();
      chk("R2", lock_pull, 1'b0, "no pull while armed");
      finish_rmw(nd, "R2");
    end

    // R3 held line, sweep hold length, grant exactly three edges after release
    for (int h = 1; h <= 5; h++) begin
      other_hold = 1;
      repeat (3) step();
      atomic_req = 1;
      step();
      chk("R3", lock_granted, 1'b0, "grant while held");
      for (int i = 0; i < h; i++) begin
        step();
        chk("R3", lock_granted, 1'b0, "grant while still held");
      end
      other_hold = 0;
      step(); chk("R3", lock_granted, 1'b0, "grant edge 1 after release");
      step(); chk("R3", lock_granted, 1'b0, "grant edge 2 after release");
      step(); chk("R3", lock_granted, 1'b1, "grant edge 3 after release");
      atomic_req = 0;
      finish_rmw(1, "R3");
    end

    // R3 interrupt acknowledge on a held line
    other_hold = 1;
    repeat (3) step();
    intack_req = 1;
    repeat (3) begin step(); chk("R3", lock_granted, 1'b0, "ack grant while held"); end
    other_hold = 0;
    repeat (2) begin step(); chk("R3", lock_pull, 1'b0, "ack pull before sync"); end
    step();
    chk("R3", lock_pull, 1'b1, "ack pull after sync");
    intack_req = 0;
    done = 1; step(); done = 0;
    settle();

    // R6 interrupt acknowledge, sweep length
    for (int n = 0; n <= 4; n++) begin
      intack_req = 1;
      step();
      chk("R6", lock_granted, 1'b1, "ack grant");
      chk("R6", lock_pull, 1'b1, "ack pull");
      intack_req = 0;
      for (int i = 0; i < n; i++) begin
        step();
        chk("R6", lock_pull, 1'b1, "ack pull held");
      end
      done = 1;
      step();
      chk("R6", lock_pull, 1'b0, "ack pull after done");
      chk("R6", lock_granted, 1'b0, "ack grant after done");
      done = 0;
      settle();
    end

    // R7 ordinary transfers
    for (int oh = 0; oh <= 1; oh++) begin
      other_hold = oh[0];
      for (int p = 0; p < 8; p++) begin
        addr_state = p[0]; is_write = p[1];
        step();
        chk("R7", lock_pull | lock_granted, 1'b0, "ordinary transfer");
      end
      addr_state = 0; is_write = 0; other_hold = 0;
      settle();
    end

    // R8 simultaneous requests
    atomic_req = 1; intack_req = 1;
    step();
    chk("R8", lock_granted, 1'b1, "grant on both requests");
    chk("R8", lock_pull, 1'b0, "atomic path chosen");
    atomic_req = 0; intack_req = 0;
    finish_rmw(2, "R8");

    // R10 reset during a wait
    other_hold = 1;
    repeat (3) step();
    atomic_req = 1;
    repeat (2) step();
    rst_n = 0; atomic_req = 0;
    #1;
    chk("R10", lock_granted, 1'b0, "grant in reset");
    other_hold = 0;
    repeat (4) step();
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R10", lock_granted | lock_pull, 1'b0, "aborted wait stays idle");
    end
    chk("R10", float_mode, 1'b0, "no float after free reset");

    // R9 float strap
    do_reset(1'b1);
    chk("R9", float_mode, 1'b1, "float set by low strap");
    other_hold = 0;
    atomic_req = 1;
    repeat (5) begin step(); chk("R9", lock_granted | lock_pull, 1'b0, "atomic ignored in float"); end
    atomic_req = 0; intack_req = 1;
    repeat (3) begin step(); chk("R9", lock_granted | lock_pull, 1'b0, "ack ignored in float"); end
    intack_req = 0;
    chk("R9", float_mode, 1'b1, "float persists");
    do_reset(1'b0);
    chk("R9", float_mode, 1'b0, "float cleared by reset");
    settle();
    atomic_req = 1; step();
    chk("R9", lock_granted, 1'b1, "grant after leaving float");
    atomic_req = 0;
    finish_rmw(1, "R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule